// File: doc/BRIEF.md
# Chopper Phase and Auxiliary Precharge Timing Generator

This block drives the switch controls of a chopper-stabilized amplifier front end that uses an auxiliary path to raise its input impedance. An external chopping clock sets the chopping frequency, so the rate can change without any change to the block. That clock is synchronized into a fast system-clock domain. The block turns each chopping edge into a pair of non-overlapping main chopper phases. Between the two phases there is a programmable dead time.

At the opening of every chopping phase, positive or negative, the block raises a precharge enable that switches on the auxiliary buffers. At the same moment it raises a shorter storage-capacitor connect pulse, which always ends before the precharge does. Two complementary auxiliary mixer controls run at one quarter of the chopping rate, so the offset of the auxiliary buffers is moved up to fc/4. A free-running duty-cycle generator drives the switch of the feedback resistor, which makes that resistor look like a much larger one.

A central state machine has four states. IDLE means every switch is open. DEAD means both main phases are open. POS and NEG each mean one main phase is closed. It has five transitions. START goes IDLE to DEAD on the first chopping edge. RESTART goes DEAD to DEAD when an edge arrives during the dead time. CLOSE_POS goes DEAD to POS when the dead time ends and the chopping level is high. CLOSE_NEG goes DEAD to NEG when the dead time ends and the chopping level is low. OPEN goes from POS or NEG to DEAD on a chopping edge. Every output is registered. All durations are counts of the fast clock, taken from configuration inputs.

Top module: `chop_timing_gen`

## Requirements
- R1: During reset, and after reset until the first change of `chop_clk_in`, all seven outputs are 0.
- R2: `phi_pos` and `phi_neg` are never 1 together. After each chopping edge, both stay 0 for exactly max(`cfg_dead`,1) fast cycles. Then the phase that matches the new synchronized level closes: `phi_pos` for level 1, `phi_neg` for level 0.
- R3: The old phase stays closed for the first SYNC_STAGES fast cycles after `chop_clk_in` changes, which is two with the defaults. It opens in cycle SYNC_STAGES+1. The new phase closes in cycle SYNC_STAGES+1+max(`cfg_dead`,1).
- R4: `pre_en` rises in the same cycle that a main phase closes. It stays 1 for `cfg_pre_len` cycles, and stays 0 for the whole phase when `cfg_pre_len` is 0. It is 1 only while a main phase is closed.
- R5: `store_en` rises together with `pre_en`. It lasts min(`cfg_store_len`, `cfg_pre_len`-1) cycles, so it always drops strictly before `pre_en`. With `cfg_pre_len` at 0 or 1, it never rises. It is 1 only while `pre_en` is 1.
- R6: The positive phases since reset are counted as n = 1, 2, 3, … From the close of positive phase n, `aux_mix_a` equals bit MIX_DIV_W-1 of n, which is bit 1 with the defaults and gives fc/4. `aux_mix_b` is its complement. Both are 0 before the first positive phase. They change only in the cycle where `phi_pos` closes.
- R7: After the first chopping edge, `rf_sw_en` is 1 for exactly min(`cfg_rf_on`, P) cycles out of every P consecutive cycles, where P = max(`cfg_rf_period`,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chop_clk_in | input | 1 | External chopping clock, asynchronous |
| cfg_dead | input | CNT_W | Dead time between main phases, in fast cycles (0 treated as 1) |
| cfg_pre_len | input | CNT_W | Precharge window length, in fast cycles |
| cfg_store_len | input | CNT_W | Storage-capacitor connect length, in fast cycles (clipped) |
| cfg_rf_on | input | CNT_W | Feedback-resistor switch on-time per period |
| cfg_rf_period | input | CNT_W | Feedback-resistor duty period (0 treated as 1) |
| phi_pos | output | 1 | Main chopper phase, closed while the chopping level is high |
| phi_neg | output | 1 | Main chopper phase, closed while the chopping level is low |
| pre_en | output | 1 | Auxiliary buffer precharge enable |
| store_en | output | 1 | Storage-capacitor connect |
| aux_mix_a | output | 1 | Auxiliary mixer control, fc/4 square wave |
| aux_mix_b | output | 1 | Complement of aux_mix_a (both 0 before the first positive phase) |
| rf_sw_en | output | 1 | Duty-cycled feedback-resistor switch enable |

## Verification
The bench builds the block with its defaults: CNT_W = 8, SYNC_STAGES = 2 and MIX_DIV_W = 2. Under these, the edge-to-phase latency is a fixed three cycles plus the dead time, and the mixer pattern repeats every four positive phases. With 40-cycle chopping half-periods, every programmed window ends well inside its phase. This lets the bench count the dead gap, the precharge width and the storage width exactly. It covers the zero dead-time clamp, a storage request longer than precharge, precharge lengths of 0 and 1, and a resistor period of 0. Seven positive phases are enough to see the 0,1,1,0 mixer sequence wrap around.

// File: rtl/chop_timing_pkg.sv
package chop_timing_pkg;

    // Controller states of the chopper sequencer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // after reset, every switch open
        ST_DEAD = 2'd1,   // both main phases open between edges
        ST_POS  = 2'd2,   // positive main phase closed
        ST_NEG  = 2'd3    // negative main phase closed
    } chop_state_e;

    // Registered switch controls produced by the sequencer
    typedef struct packed {
        logic phi_pos;
        logic phi_neg;
        logic pre;
        logic store;
    } phase_ctl_t;

endpackage

// File: rtl/chop_edge_sync.sv
module chop_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic toggle
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   level_d;

    // Stage 0 samples the asynchronous chopping clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain[0] <= 1'b0;
        end else begin
            chain[0] <= async_in;
        end
    end

    // Remaining metastability stages
    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else begin
                    chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_d <= 1'b0;
        end else begin
            level_d <= chain[LAST];
        end
    end

    assign level  = chain[LAST];
    assign toggle = chain[LAST] ^ level_d;

endmodule

// File: rtl/chop_phase_fsm.sv
module chop_phase_fsm
    import chop_timing_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             toggle,
    input  logic [CNT_W-1:0] cfg_dead,
    input  logic [CNT_W-1:0] cfg_pre_len,
    input  logic [CNT_W-1:0] cfg_store_len,
    output phase_ctl_t       ctl,
    output logic             pos_entry,
    output logic             active
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W:0]   ONE_X   = (CNT_W+1)'(1);

    chop_state_e      state, state_nx;
    logic [CNT_W-1:0] dcnt, dcnt_nx;
    logic [CNT_W-1:0] pc, pc_nx;
    logic [CNT_W-1:0] dead_eff;
    logic [CNT_W-1:0] store_eff;
    logic [CNT_W:0]   dcnt_inc;
    logic             in_phase_nx;

    // Zero dead time would let phases touch; clamp to one cycle
    assign dead_eff = (cfg_dead == '0) ? ONE : cfg_dead;

    // Storage pulse must end strictly before precharge ends
    always_comb begin
        if (cfg_pre_len == '0) begin
            store_eff = '0;
        end else if (cfg_store_len >= cfg_pre_len) begin
            store_eff = cfg_pre_len - ONE;
        end else begin
            store_eff = cfg_store_len;
        end
    end

    assign dcnt_inc = {1'b0, dcnt} + ONE_X;

    // Next-state logic with named transitions
    always_comb begin
        state_nx = state;
        dcnt_nx  = dcnt;
        pc_nx    = pc;
        unique case (state)
            ST_IDLE: begin
                if (toggle) begin              // START
                    state_nx = ST_DEAD;
                    dcnt_nx  = '0;
                end
            end
            ST_DEAD: begin
                if (toggle) begin              // RESTART
                    dcnt_nx = '0;
                end else if (dcnt_inc >= {1'b0, dead_eff}) begin
                    state_nx = level ? ST_POS : ST_NEG;  // CLOSE_POS / CLOSE_NEG
                    pc_nx    = '0;
                end else begin
                    dcnt_nx = dcnt_inc[CNT_W-1:0];
                end
            end
            ST_POS, ST_NEG: begin
                if (toggle) begin              // OPEN
                    state_nx = ST_DEAD;
                    dcnt_nx  = '0;
                end else if (pc != CNT_MAX) begin
                    pc_nx = pc + ONE;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    assign pos_entry   = (state == ST_DEAD) && (state_nx == ST_POS);
    assign in_phase_nx = (state_nx == ST_POS) || (state_nx == ST_NEG);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            dcnt  <= '0;
            pc    <= '0;
        end else begin
            state <= state_nx;
            dcnt  <= dcnt_nx;
            pc    <= pc_nx;
        end
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl    <= '0;
            active <= 1'b0;
        end else begin
            ctl.phi_pos <= (state_nx == ST_POS);
            ctl.phi_neg <= (state_nx == ST_NEG);
            ctl.pre     <= in_phase_nx && (pc_nx < cfg_pre_len);
            ctl.store   <= in_phase_nx && (pc_nx < store_eff);
            active      <= (state_nx != ST_IDLE);
        end
    end

endmodule

// File: rtl/chop_aux_mixer.sv
module chop_aux_mixer #(
    parameter int MIX_DIV_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_entry,
    output logic mix_a,
    output logic mix_b
);

    localparam int                 TOP = MIX_DIV_W - 1;
    localparam logic [MIX_DIV_W-1:0] ONE = MIX_DIV_W'(1);

    logic [MIX_DIV_W-1:0] pcount, pcount_nx;
    logic                 armed, armed_nx;

    always_comb begin
        pcount_nx = pcount;
        armed_nx  = armed;
        if (pos_entry) begin
            pcount_nx = pcount + ONE;
            armed_nx  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcount <= '0;
            armed  <= 1'b0;
            mix_a  <= 1'b0;
            mix_b  <= 1'b0;
        end else begin
            pcount <= pcount_nx;
            armed  <= armed_nx;
            mix_a  <= armed_nx &  pcount_nx[TOP];
            mix_b  <= armed_nx & ~pcount_nx[TOP];
        end
    end

endmodule

// File: rtl/chop_rf_duty.sv
module chop_rf_duty #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cfg_on,
    input  logic [CNT_W-1:0] cfg_period,
    output logic             rf_en
);

    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W:0]   ONE_X = (CNT_W+1)'(1);

    logic [CNT_W-1:0] slot;
    logic [CNT_W-1:0] per_eff;
    logic [CNT_W:0]   slot_inc;

    assign per_eff  = (cfg_period == '0) ? ONE : cfg_period;
    assign slot_inc = {1'b0, slot} + ONE_X;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot  <= '0;
            rf_en <= 1'b0;
        end else begin
            slot  <= (slot_inc >= {1'b0, per_eff}) ? '0 : slot_inc[CNT_W-1:0];
            rf_en <= run && (slot < cfg_on);
        end
    end

endmodule

// File: rtl/chop_timing_gen.sv
module chop_timing_gen
    import chop_timing_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIX_DIV_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chop_clk_in,
    input  logic [CNT_W-1:0] cfg_dead,
    input  logic [CNT_W-1:0] cfg_pre_len,
    input  logic [CNT_W-1:0] cfg_store_len,
    input  logic [CNT_W-1:0] cfg_rf_on,
    input  logic [CNT_W-1:0] cfg_rf_period,
    output logic             phi_pos,
    output logic             phi_neg,
    output logic             pre_en,
    output logic             store_en,
    output logic             aux_mix_a,
    output logic             aux_mix_b,
    output logic             rf_sw_en
);

    logic       chop_level;
    logic       chop_toggle;
    logic       pos_entry;
    logic       seq_active;
    phase_ctl_t ctl;

    chop_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (chop_clk_in),
        .level    (chop_level),
        .toggle   (chop_toggle)
    );

    chop_phase_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .level         (chop_level),
        .toggle        (chop_toggle),
        .cfg_dead      (cfg_dead),
        .cfg_pre_len   (cfg_pre_len),
        .cfg_store_len (cfg_store_len),
        .ctl           (ctl),
        .pos_entry     (pos_entry),
        .active        (seq_active)
    );

    chop_aux_mixer #(
        .MIX_DIV_W (MIX_DIV_W)
    ) u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos_entry (pos_entry),
        .mix_a     (aux_mix_a),
        .mix_b     (aux_mix_b)
    );

    chop_rf_duty #(
        .CNT_W (CNT_W)
    ) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (seq_active),
        .cfg_on     (cfg_rf_on),
        .cfg_period (cfg_rf_period),
        .rf_en      (rf_sw_en)
    );

    assign phi_pos  = ctl.phi_pos;
    assign phi_neg  = ctl.phi_neg;
    assign pre_en   = ctl.pre;
    assign store_en = ctl.store;

endmodule

// File: rtl/chop_timing_gen_chk.sv
module chop_timing_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic phi_pos,
    input logic phi_neg,
    input logic pre_en,
    input logic store_en,
    input logic aux_mix_a,
    input logic aux_mix_b
);

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi_pos && phi_neg));

    assert_pos_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi_pos) |-> !$past(phi_neg));

    assert_neg_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi_neg) |-> !$past(phi_pos));

    assert_pre_in_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> (phi_pos || phi_neg));

    assert_store_in_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
        store_en |-> pre_en);

    assert_mix_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(aux_mix_a && aux_mix_b));

    assert_mix_moves_on_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_mix_a != $past(aux_mix_a)) |-> $rose(phi_pos));

endmodule

bind chop_timing_gen chop_timing_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phi_pos   (phi_pos),
    .phi_neg   (phi_neg),
    .pre_en    (pre_en),
    .store_en  (store_en),
    .aux_mix_a (aux_mix_a),
    .aux_mix_b (aux_mix_b)
);

// File: tb/chop_timing_gen_bench.sv
`timescale 1ns/1ps
module chop_timing_gen_bench;

    localparam int HALF = 40;
    localparam int NV   = 6;

    typedef struct packed {
        logic [7:0] dead;
        logic [7:0] pre;
        logic [7:0] store;
        logic [7:0] gap;
        logic [7:0] epre;
        logic [7:0] estore;
    } vec_t;

    // dead, pre, store -> expected gap, precharge width, storage width
    localparam vec_t VECS [NV] = '{
        '{8'd1, 8'd5, 8'd2, 8'd1, 8'd5, 8'd2},
        '{8'd0, 8'd4, 8'd1, 8'd1, 8'd4, 8'd1},
        '{8'd3, 8'd6, 8'd9, 8'd3, 8'd6, 8'd5},
        '{8'd2, 8'd1, 8'd1, 8'd2, 8'd1, 8'd0},
        '{8'd4, 8'd0, 8'd3, 8'd4, 8'd0, 8'd0},
        '{8'd2, 8'd8, 8'd7, 8'd2, 8'd8, 8'd7}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       chop_clk_in;
    logic [7:0] cfg_dead, cfg_pre_len, cfg_store_len, cfg_rf_on, cfg_rf_period;
    logic       phi_pos, phi_neg, pre_en, store_en, aux_mix_a, aux_mix_b, rf_sw_en;

    int  checks   = 0;
    int  failures = 0;
    int  n_pos    = 0;
    logic lvl     = 1'b0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    chop_timing_gen u_chop_timing_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .chop_clk_in   (chop_clk_in),
        .cfg_dead      (cfg_dead),
        .cfg_pre_len   (cfg_pre_len),
        .cfg_store_len (cfg_store_len),
        .cfg_rf_on     (cfg_rf_on),
        .cfg_rf_period (cfg_rf_period),
        .phi_pos       (phi_pos),
        .phi_neg       (phi_neg),
        .pre_en        (pre_en),
        .store_en      (store_en),
        .aux_mix_a     (aux_mix_a),
        .aux_mix_b     (aux_mix_b),
        .rf_sw_en      (rf_sw_en)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int all_outs();
        return {25'd0, phi_pos, phi_neg, pre_en, store_en, aux_mix_a, aux_mix_b, rf_sw_en};
    endfunction

    // Toggle the chopping clock and observe one half-period
    task automatic run_half(input int egap, input int epre, input int estore, input bit timing);
        int old_on = 0, both = 0, npre = 0, nstore = 0, first_new = 0, ovl = 0;
        int pre_first = 0, st_first = 0, exp_a, exp_b;
        logic now_on, was_on;
        @(negedge clk);
        lvl = !lvl;
        chop_clk_in = lvl;
        if (lvl) n_pos++;
        for (int i = 1; i <= HALF; i++) begin
            @(negedge clk);
            now_on = lvl ? phi_pos : phi_neg;
            was_on = lvl ? phi_neg : phi_pos;
            if (phi_pos && phi_neg) ovl++;
            if (was_on) old_on++;
            if (!phi_pos && !phi_neg) both++;
            if (now_on && first_new == 0) begin
                first_new = i;
                pre_first = int'(pre_en);
                st_first  = int'(store_en);
            end
            if (pre_en) npre++;
            if (store_en) nstore++;
        end
        chk("R2", "phase overlap samples", ovl, 0);
        chk("R2", "new phase closed at end", int'(now_on && !was_on), 1);
        exp_a = (n_pos > 0) ? ((n_pos >> 1) & 1) : 0;
        exp_b = (n_pos > 0) ? (1 - exp_a) : 0;
        chk("R6", "aux_mix_a", int'(aux_mix_a), exp_a);
        chk("R6", "aux_mix_b", int'(aux_mix_b), exp_b);
        if (timing) begin
            chk("R3", "old phase hold cycles", old_on, 2);
            chk("R3", "new phase close cycle", first_new, 3 + egap);
            chk("R2", "dead gap cycles", both, egap);
            chk("R4", "precharge cycles", npre, epre);
            chk("R4", "precharge at phase close", pre_first, (epre > 0) ? 1 : 0);
            chk("R5", "storage cycles", nstore, estore);
            chk("R5", "storage at phase close", st_first, (estore > 0) ? 1 : 0);
        end
    endtask

    task automatic rf_window(input int on, input int per, input string what);
        int cnt = 0;
        int pe = (per == 0) ? 1 : per;
        @(negedge clk);
        cfg_rf_on     = 8'(on);
        cfg_rf_period = 8'(per);
        repeat (20) @(negedge clk);
        for (int i = 0; i < 3 * pe; i++) begin
            if (rf_sw_en) cnt++;
            @(negedge clk);
        end
        chk("R7", what, cnt, 3 * ((on < pe) ? on : pe));
    endtask

    initial begin
        rst_n = 1'b0;
        chop_clk_in = 1'b0;
        cfg_dead = 8'd1; cfg_pre_len = 8'd5; cfg_store_len = 8'd2;
        cfg_rf_on = 8'd3; cfg_rf_period = 8'd8;
        repeat (3) @(negedge clk);
        chk("R1", "outputs in reset", all_outs(), 0);
        rst_n = 1'b1;
        repeat (25) @(negedge clk);
        chk("R1", "outputs idle before first edge", all_outs(), 0);

        // Warm-up half-period from idle: first positive phase
        run_half(0, 0, 0, 1'b0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            cfg_dead      = VECS[v].dead;
            cfg_pre_len   = VECS[v].pre;
            cfg_store_len = VECS[v].store;
            for (int h = 0; h < 2; h++) begin
                run_half(int'(VECS[v].gap), int'(VECS[v].epre), int'(VECS[v].estore), 1'b1);
            end
        end

        // Directed: reset in mid-run returns everything to the safe state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "outputs during mid-run reset", all_outs(), 0);
        chop_clk_in = 1'b0;
        lvl = 1'b0;
        n_pos = 0;
        cfg_dead = 8'd2; cfg_pre_len = 8'd3; cfg_store_len = 8'd1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk("R1", "outputs idle after reset", all_outs(), 0);
        chk("R7", "rf switch idle before first edge", int'(rf_sw_en), 0);
        run_half(0, 0, 0, 1'b0);
        run_half(2, 3, 1, 1'b1);

        // Directed: resistor duty cases
        rf_window(3, 8, "duty 3 of 8");
        rf_window(10, 8, "on-time beyond period");
        rf_window(0, 5, "zero on-time");
        rf_window(2, 0, "zero period");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule